// File: doc/BRIEF.md
# Single-Conversion ADC Start Controller

This block sits beside one analog-to-digital converter channel and decides when that channel starts a single conversion. It holds one 8-bit control and status byte that software writes and reads through a simple write strobe and a read bus. A conversion can be started in two ways. Software can start it by writing a start bit. It can also be started by a rising edge on one of four hardware trigger lines, chosen by a two-bit code whose halves sit in non-adjacent register bits.

The block sends the converter core a one-cycle start pulse, or a one-cycle abort pulse when software asks for a stop. It watches the core's done pulse and keeps a completed flag. When a conversion finishes normally, it raises a one-cycle request on either an interrupt line or a DMA line, depending on a routing bit. While a comparator-mode input is high, the hardware trigger lines are ignored and only software can start the channel.

Top module: `adc_single_ctrl`

## Requirements
Register bits are numbered with bit 7 as the most significant. The layout is:
- bit 7: trigger code high
- bit 6: unused
- bit 5: trigger code low
- bit 4: start source (0 = software, 1 = hardware)
- bit 3: routing (0 = interrupt, 1 = DMA)
- bit 2: completed flag
- bit 1: stop
- bit 0: start

- R1: After reset, `rd_data` reads 0x04: the completed flag is 1 and every other bit is 0.
- R2: A write stores bits 7, 5, 4 and 3, and they read back unchanged. Bits 6, 1 and 0 always read 0. Bit 2 is never changed by a write.
- R3: Writing 1 to bit 0 while idle (and bit 1 = 0) raises `conv_start` for exactly one cycle, at the clock edge that takes the write. The completed flag reads 0 from that same edge.
- R4: While a conversion is running, neither a software start nor a hardware trigger edge produces another `conv_start`.
- R5: When bit 4 = 1 and `cmp_mode` = 0, the code {bit 7, bit 5} (binary 00 to 11) selects `hw_trig[code]`. A rising edge on that input raises `conv_start` SYNC_STAGES+1 clock edges after it is first sampled. Edges on the other inputs are ignored.
- R6: When bit 4 = 0, edges on any hardware trigger input start nothing.
- R7: While `cmp_mode` = 1, hardware trigger edges start nothing even with bit 4 = 1, but a software start still works.
- R8: Writing 1 to bit 1 raises `conv_stop` for one cycle at the edge that takes the write and ends the running conversion. The completed flag reads 1 one cycle later, and neither `irq_req` nor `dma_req` pulses.
- R9: A write with both bit 1 and bit 0 set produces `conv_stop` and no `conv_start`.
- R10: A `conv_done` pulse during a conversion sets the completed flag at the next edge. At that same edge it raises a one-cycle `irq_req` if bit 3 = 0, or `dma_req` if bit 3 = 1. A `conv_done` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control and status readback |
| hw_trig | input | 4 | Asynchronous hardware trigger lines |
| cmp_mode | input | 1 | Comparator mode: hardware triggers disabled |
| conv_done | input | 1 | Converter finished pulse |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_stop | output | 1 | One-cycle abort pulse to the converter |
| irq_req | output | 1 | Completion interrupt request pulse |
| dma_req | output | 1 | Completion DMA request pulse |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default of 2. This makes the trigger latency check depend on the parameter and not on a fixed two-stage chain. All four trigger codes are driven, and each is checked against both its own line and a line it must not react to. The start-source bit, comparator mode and the busy state are each checked against the same hardware edge, so each one is shown to block it separately.

// File: rtl/adc_single_ctrl.sv
module adc_single_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [3:0] hw_trig,
  input  logic       cmp_mode,
  input  logic       conv_done,
  output logic       conv_start,
  output logic       conv_stop,
  output logic       irq_req,
  output logic       dma_req
);

  logic       sel_hi, sel_lo, src_hw, route_dma, cmpl, busy;
  logic [3:0] stg [SYNC_STAGES];
  logic [3:0] trig_prev;
  logic [3:0] trig_rise;
  logic       sw_go, stop_go, hw_go, go, done_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
      trig_prev <= '0;
    end else begin
      stg[0] <= hw_trig;
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      trig_prev <= stg[SYNC_STAGES-1];
    end
  end

  assign trig_rise = stg[SYNC_STAGES-1] & ~trig_prev;

  assign stop_go = wr_en & wr_data[1];
  assign sw_go   = wr_en & wr_data[0];
  assign hw_go   = src_hw & ~cmp_mode & trig_rise[{sel_hi, sel_lo}];
  assign go      = ~busy & ~stop_go & (sw_go | hw_go);
  assign done_ok = busy & conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi <= 1'b0; sel_lo <= 1'b0; src_hw <= 1'b0; route_dma <= 1'b0;
    end else if (wr_en) begin
      sel_hi    <= wr_data[7];
      sel_lo    <= wr_data[5];
      src_hw    <= wr_data[4];
      route_dma <= wr_data[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cmpl       <= 1'b1;
      conv_start <= 1'b0;
      conv_stop  <= 1'b0;
      irq_req    <= 1'b0;
      dma_req    <= 1'b0;
    end else begin
      conv_start <= go;
      conv_stop  <= stop_go;
      irq_req    <= done_ok & ~route_dma;
      dma_req    <= done_ok & route_dma;
      if (go) busy <= 1'b1;
      else if (stop_go || done_ok) busy <= 1'b0;
      if (go) cmpl <= 1'b0;
      else if (done_ok || conv_stop) cmpl <= 1'b1;
    end
  end

  assign rd_data = {sel_hi, 1'b0, sel_lo, src_hw, route_dma, cmpl, 2'b00};

endmodule

module adc_single_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       conv_done,
  input logic       conv_start,
  input logic       conv_stop,
  input logic       irq_req,
  input logic       dma_req
);
  // R2
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] == 1'b0 && rd_data[1:0] == 2'b00);
  // R3
  start_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !rd_data[2]);
  // R9
  stop_beats_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1]) |=> (conv_stop && !conv_start));
  // R10
  one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_req, dma_req}));
  // R10
  req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req || dma_req) |-> rd_data[2]);
  // R10
  req_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req || dma_req) |-> $past(conv_done));
endmodule

bind adc_single_ctrl adc_single_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .conv_done(conv_done), .conv_start(conv_start), .conv_stop(conv_stop),
  .irq_req(irq_req), .dma_req(dma_req)
);

// File: tb/adc_single_ctrl_test.sv
module adc_single_ctrl_test;
  localparam int S = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] hw_trig = '0;
  logic       cmp_mode = 1'b0;
  logic       conv_done = 1'b0;
  logic       conv_start, conv_stop, irq_req, dma_req;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] cfg;

  always #10 clk = ~clk;

  adc_single_ctrl #(.SYNC_STAGES(S)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .hw_trig(hw_trig), .cmp_mode(cmp_mode), .conv_done(conv_done),
    .conv_start(conv_start), .conv_stop(conv_stop), .irq_req(irq_req), .dma_req(dma_req)
  );

  function automatic logic [7:0] exp_rd(input logic [7:0] w, input logic flag);
    return (w & 8'hB8) | (flag ? 8'h04 : 8'h00);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic done_pulse();
    conv_done = 1'b1; tick(); conv_done = 1'b0;
  endtask

  task automatic trig_expect_none(input int idx, input string req);
    logic seen = 1'b0;
    hw_trig[idx] = 1'b1;
    for (int i = 0; i < S + 3; i++) begin tick(); seen |= conv_start; end
    check(req, {7'b0, seen}, 8'h00);
    hw_trig[idx] = 1'b0;
    repeat (S + 2) tick();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 reset value", rd_data, 8'h04);
    check("R1 outputs idle", {4'b0, conv_start, conv_stop, irq_req, dma_req}, 8'h00);

    // R2 random config writes
    for (int n = 0; n < 24; n++) begin
      cfg = 8'($urandom) & 8'hFC;
      wr(cfg);
      check("R2 readback", rd_data, exp_rd(cfg, 1'b1));
    end

    // R3 / R10 software start, interrupt routing
    wr(8'h01);
    check("R3 start pulse", {7'b0, conv_start}, 8'h01);
    check("R3 flag cleared", rd_data, 8'h00);
    tick();
    check("R3 single pulse", {7'b0, conv_start}, 8'h00);
    wr(8'h01);
    check("R4 sw start ignored while busy", {7'b0, conv_start}, 8'h00);
    done_pulse();
    check("R10 irq pulse", {6'b0, irq_req, dma_req}, 8'h02);
    check("R10 flag set", rd_data, 8'h04);
    tick();
    check("R10 irq one cycle", {6'b0, irq_req, dma_req}, 8'h00);

    // R10 DMA routing
    wr(8'h09);
    done_pulse();
    check("R10 dma pulse", {6'b0, irq_req, dma_req}, 8'h01);
    tick();
    done_pulse();
    check("R10 done while idle ignored", {6'b0, irq_req, dma_req}, 8'h00);

    // R5 each trigger code
    for (int c = 0; c < 4; c++) begin
      cfg = {c[1], 1'b0, c[0], 1'b1, 4'b0};
      wr(cfg);
      trig_expect_none((c + 1) % 4, "R5 other input ignored");
      hw_trig[c] = 1'b1;
      repeat (S) tick();
      check("R5 no start before latency", {7'b0, conv_start}, 8'h00);
      tick();
      check("R5 hw start", {7'b0, conv_start}, 8'h01);
      hw_trig[c] = 1'b0;
      done_pulse();
      check("R10 irq after hw start", {6'b0, irq_req, dma_req}, 8'h02);
      repeat (S + 2) tick();
    end

    // R6 software source ignores triggers
    wr(8'hA0);
    trig_expect_none(3, "R6 hw ignored with sw source");
    check("R6 flag untouched", rd_data, 8'hA4);

    // R7 comparator mode
    wr(8'h10);
    cmp_mode = 1'b1;
    trig_expect_none(0, "R7 hw ignored in cmp mode");
    wr(8'h11);
    check("R7 sw start in cmp mode", {7'b0, conv_start}, 8'h01);
    cmp_mode = 1'b0;

    // R4 hw edge while busy
    trig_expect_none(0, "R4 hw ignored while busy");

    // R8 stop
    wr(8'h12);
    check("R8 stop pulse", {6'b0, conv_start, conv_stop}, 8'h01);
    check("R8 flag not yet set", rd_data, 8'h10);
    tick();
    check("R8 flag set after stop", rd_data, 8'h14);
    done_pulse();
    check("R8 no request after abort", {6'b0, irq_req, dma_req}, 8'h00);

    // R9 start and stop together
    wr(8'h03);
    check("R9 stop wins", {6'b0, conv_start, conv_stop}, 8'h01);
    tick();
    check("R9 no conversion", rd_data, 8'h04);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule